// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block takes one decoded multi-register memory instruction and cracks it into an ordered stream of single-register micro-ops. The instruction arrives with a 16-bit register list, five mode bits and a 4-bit base register number. The block emits one micro-op per output handshake, in this order:

- a copy of the base register;
- one load or store for each register in the list;
- optionally, a micro-op that writes the updated base back.

Each micro-op carries a signed 32-bit byte offset, measured from the copied base. A downstream stage adds that offset to the base to form the address.

Both edges of the block use valid/ready handshakes. The input handshake completes when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high only while the sequencer is idle, so the input is back-pressured for the whole expansion. The output handshake completes when `out_valid` and `out_ready` are both high at a rising edge. While `out_valid` is high and `out_ready` is low, the current micro-op is held unchanged. If the mode code is unsupported, or the register list is empty, the instruction is still accepted. The block then raises `err` for one cycle and emits no micro-ops.

Top module: `lsm_seq`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, `err` is 0 and `in_ready` is 1.
- R2: The first micro-op of every accepted, valid instruction is a base copy. It has kind 0, reg equal to the base number, offset 0 and last 0.
- R3: The block emits one transfer micro-op (kind 1) for each set bit of the register list. Register numbers come out in ascending order.
- R4: The mode bits are P = bit 4, U = bit 3, S = bit 2, W = bit 1 and L = bit 0. With c equal to the number of set list bits, the first transfer offset depends on P and U:

  | P | U | Addressing mode | First offset |
  |---|---|---|---|
  | 0 | 1 | increment-after | 0 |
  | 1 | 1 | increment-before | 4 |
  | 0 | 0 | decrement-after | 4c−4 |
  | 1 | 0 | decrement-before | 4c |

  Each later transfer's offset is 4 more than the previous one when U = 1, and 4 less when U = 0.
- R5: When W = 1, the final micro-op updates the base register. Its kind is 2 (add) when U = 1 and 3 (subtract) when U = 0. Its reg is the base number and its offset is 4c.
- R6: `out_last` is 1 on the final micro-op of a sequence and 0 on every other micro-op.
- R7: The block accepts only the mode codes 0x01, 0x03, 0x08, 0x09, 0x0B, 0x11, 0x12, 0x18 and 0x19. Any other code is still accepted by the input handshake. One cycle after acceptance, `err` is 1 for one cycle, and no micro-op is emitted.
- R8: An empty register list is treated like R7: `err` is pulsed and no micro-op is emitted.
- R9: `in_ready` is 0 from acceptance of a valid instruction until its last micro-op has been taken. While `out_valid` is 1 and `out_ready` is 0, every micro-op output holds its value into the next cycle.
- R10: `out_load` equals the L mode bit on every transfer micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Sequencer idle and able to accept an instruction |
| in_reglist | input | 16 | Register list; bit n selects register n |
| in_mode | input | 5 | Mode bits {P,U,S,W,L} |
| in_base | input | 4 | Base register number |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 2 | Micro-op kind: 0 copy, 1 transfer, 2 base add, 3 base subtract |
| out_reg | output | 4 | Register index |
| out_offset | output | 32 | Signed byte offset, two's complement |
| out_load | output | 1 | L bit of the instruction: 1 load, 0 store |
| out_last | output | 1 | Final micro-op of the sequence |
| err | output | 1 | One-cycle pulse for an unsupported code or an empty list |

## Verification
The hardest situations to reach are a stall in the middle of a long transfer run and a stall on the writeback step.

- A long run uses the full 16-register list.
- In both cases `out_ready` must drop exactly while a micro-op is pending, so that the held offset and register can be compared across cycles.

The bench drives `out_ready` from a pseudo-random shift register during the stalled tests. It then checks that a blocked micro-op repeats unchanged, and that the input stays not-ready throughout. Sparse lists such as 0x8001 and 0x1234 make the lowest-bit search skip wide gaps. The decrement modes check the downward offset sequences.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    UOP_COPY = 2'd0,
    UOP_XFER = 2'd1,
    UOP_ADD  = 2'd2,
    UOP_SUB  = 2'd3
  } uop_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COPY,
    ST_XFER,
    ST_WB
  } seq_state_e;

  localparam int MODE_W = 5;
  localparam int BIT_P  = 4;
  localparam int BIT_U  = 3;
  localparam int BIT_W  = 1;
  localparam int BIT_L  = 0;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  logic [CW-1:0] acc [0:W];

  assign acc[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_sum
    assign acc[g+1] = acc[g] + CW'(vec[g]);
  end
  assign count = acc[W];
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign onehot = vec & (~vec + W'(1));
endmodule

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode
  import lsm_pkg::*;
#(
  parameter int CW    = 5,
  parameter int OFF_W = 32,
  parameter int STEP  = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [CW-1:0]     count,
  output logic              supported,
  output logic              up,
  output logic              wb,
  output logic              load,
  output logic [OFF_W-1:0]  span,
  output logic [OFF_W-1:0]  start_off
);
  localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

  always_comb begin
    case (mode)
      5'h01, 5'h03, 5'h08, 5'h09, 5'h0B,
      5'h11, 5'h12, 5'h18, 5'h19: supported = 1'b1;
      default:                    supported = 1'b0;
    endcase
  end

  assign up   = mode[BIT_U];
  assign wb   = mode[BIT_W];
  assign load = mode[BIT_L];
  assign span = OFF_W'(count) * STEP_V;

  always_comb begin
    case ({mode[BIT_P], mode[BIT_U]})
      2'b01:   start_off = '0;
      2'b11:   start_off = STEP_V;
      2'b00:   start_off = span - STEP_V;
      default: start_off = span;
    endcase
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int REGS  = 16,
  parameter int OFF_W = 32,
  parameter int STEP  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [REGS-1:0]         in_reglist,
  input  logic [MODE_W-1:0]       in_mode,
  input  logic [$clog2(REGS)-1:0] in_base,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [1:0]              out_kind,
  output logic [$clog2(REGS)-1:0] out_reg,
  output logic [OFF_W-1:0]        out_offset,
  output logic                    out_load,
  output logic                    out_last,
  output logic                    err
);
  localparam int IW = $clog2(REGS);
  localparam int CW = $clog2(REGS + 1);
  localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

  seq_state_e       state_q;
  logic [REGS-1:0]  list_q;
  logic [IW-1:0]    base_q;
  logic             up_q, wb_q, load_q, err_q;
  logic [CW-1:0]    rem_q;
  logic [OFF_W-1:0] off_q, span_q;

  logic [CW-1:0]    in_count;
  logic             dec_ok, dec_up, dec_wb, dec_load;
  logic [OFF_W-1:0] dec_span, dec_start;
  logic [IW-1:0]    pick_idx;
  logic [REGS-1:0]  pick_onehot;
  logic             take;
  logic             last_xfer;

  lsm_popcount #(.W(REGS), .CW(CW)) u_count (
    .vec   (in_reglist),
    .count (in_count)
  );

  lsm_mode_decode #(.CW(CW), .OFF_W(OFF_W), .STEP(STEP)) u_decode (
    .mode      (in_mode),
    .count     (in_count),
    .supported (dec_ok),
    .up        (dec_up),
    .wb        (dec_wb),
    .load      (dec_load),
    .span      (dec_span),
    .start_off (dec_start)
  );

  lsm_lowbit #(.W(REGS), .IW(IW)) u_pick (
    .vec    (list_q),
    .idx    (pick_idx),
    .onehot (pick_onehot)
  );

  assign take      = out_valid && out_ready;
  assign last_xfer = (rem_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      list_q  <= '0;
      base_q  <= '0;
      up_q    <= 1'b0;
      wb_q    <= 1'b0;
      load_q  <= 1'b0;
      err_q   <= 1'b0;
      rem_q   <= '0;
      off_q   <= '0;
      span_q  <= '0;
    end else begin
      err_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            if (dec_ok && (in_count != '0)) begin
              state_q <= ST_COPY;
              list_q  <= in_reglist;
              base_q  <= in_base;
              up_q    <= dec_up;
              wb_q    <= dec_wb;
              load_q  <= dec_load;
              rem_q   <= in_count;
              off_q   <= dec_start;
              span_q  <= dec_span;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_COPY: begin
          if (take) state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (take) begin
            list_q <= list_q & ~pick_onehot;
            off_q  <= up_q ? off_q + STEP_V : off_q - STEP_V;
            rem_q  <= rem_q - CW'(1);
            if (last_xfer) state_q <= wb_q ? ST_WB : ST_IDLE;
          end
        end
        default: begin
          if (take) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q != ST_IDLE);
  assign err       = err_q;
  assign out_load  = load_q;

  always_comb begin
    out_kind   = UOP_COPY;
    out_reg    = base_q;
    out_offset = '0;
    out_last   = 1'b0;
    case (state_q)
      ST_XFER: begin
        out_kind   = UOP_XFER;
        out_reg    = pick_idx;
        out_offset = off_q;
        out_last   = last_xfer && !wb_q;
      end
      ST_WB: begin
        out_kind   = up_q ? UOP_ADD : UOP_SUB;
        out_offset = span_q;
        out_last   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int IW    = 4,
  parameter int OFF_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_kind,
  input logic [IW-1:0]    out_reg,
  input logic [OFF_W-1:0] out_offset,
  input logic             out_last,
  input logic             err
);
  logic hs;
  logic xfer_now;
  assign hs       = out_valid && out_ready;
  assign xfer_now = out_valid && (out_kind == 2'd1);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_reg)
      && $stable(out_offset) && $stable(out_last)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> !out_valid);

  assert_first_copy_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_kind == 2'd0 && out_offset == '0 && !out_last));

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (hs && out_last) |=> !out_valid);

  assert_reg_order_R3: assert property (@(posedge clk) disable iff (rst)
    (hs && xfer_now) |=> (!xfer_now || out_reg > $past(out_reg)));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (hs && xfer_now) |=> (!xfer_now || (out_offset - $past(out_offset)) == OFF_W'(4)
      || ($past(out_offset) - out_offset) == OFF_W'(4)));
endmodule

bind lsm_seq lsm_seq_chk #(.IW($clog2(REGS)), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_kind   (out_kind),
  .out_reg    (out_reg),
  .out_offset (out_offset),
  .out_last   (out_last),
  .err        (err)
);

// File: tb/tb_lsm_seq.sv
module tb_lsm_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_reglist = '0;
  logic [4:0]  in_mode = '0;
  logic [3:0]  in_base = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_kind;
  logic [3:0]  out_reg;
  logic [31:0] out_offset;
  logic        out_load;
  logic        out_last;
  logic        err;

  int tests = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  lsm_seq dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_reglist(in_reglist), .in_mode(in_mode), .in_base(in_base),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_reg(out_reg), .out_offset(out_offset), .out_load(out_load),
    .out_last(out_last), .err(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [15:0] list, input logic [4:0] mode,
                         input logic [3:0] base, input bit stall);
    logic [1:0]  ek [0:17];
    logic [3:0]  er [0:17];
    logic [31:0] eo [0:17];
    logic        el [0:17];
    logic [1:0]  gk [0:17];
    logic [3:0]  gr [0:17];
    logic [31:0] go [0:17];
    logic        gl [0:17];
    logic        gd [0:17];
    int ne, ng, c, cyc;
    logic [31:0] off;
    bit done, busy_bad, hold_bad, blocked;
    logic [1:0] pk; logic [3:0] pr; logic [31:0] po; logic pl;
    c = 0;
    for (int i = 0; i < 16; i++) if (list[i]) c++;
    ne = 0;
    ek[0] = 2'd0; er[0] = base; eo[0] = 0; el[0] = 0; ne = 1;
    case ({mode[4], mode[3]})
      2'b01: off = 0;
      2'b11: off = 4;
      2'b00: off = 32'(c * 4 - 4);
      default: off = 32'(c * 4);
    endcase
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        ek[ne] = 2'd1; er[ne] = 4'(i); eo[ne] = off; el[ne] = 0; ne++;
        off = mode[3] ? off + 4 : off - 4;
      end
    end
    if (mode[1]) begin
      ek[ne] = mode[3] ? 2'd2 : 2'd3; er[ne] = base; eo[ne] = 32'(c * 4); el[ne] = 0; ne++;
    end
    el[ne-1] = 1;

    @(negedge clk);
    in_valid = 1; in_reglist = list; in_mode = mode; in_base = base;
    @(negedge clk);
    in_valid = 0;
    ng = 0; cyc = 0; done = 0; busy_bad = 0; hold_bad = 0; blocked = 0;
    pk = 0; pr = 0; po = 0; pl = 0;
    while (!done && cyc < 400) begin
      if (blocked && (!out_valid || out_kind != pk || out_reg != pr
                      || out_offset != po || out_last != pl)) hold_bad = 1;
      if (stall) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0];
      end else out_ready = 1;
      if (out_valid && in_ready) busy_bad = 1;
      blocked = out_valid && !out_ready;
      pk = out_kind; pr = out_reg; po = out_offset; pl = out_last;
      if (out_valid && out_ready && ng < 18) begin
        gk[ng] = out_kind; gr[ng] = out_reg; go[ng] = out_offset;
        gl[ng] = out_last; gd[ng] = out_load; ng++;
        if (out_last) done = 1;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 0;
    chk(ng == ne, "R3 micro-op count", ng, ne);
    chk(!busy_bad, "R9 input not ready while busy", busy_bad, 0);
    chk(!hold_bad, "R9 output held under backpressure", hold_bad, 0);
    chk(!out_valid && in_ready, "R9 idle after last", out_valid, 0);
    for (int i = 0; i < ne && i < ng; i++) begin
      chk(gk[i] == ek[i], (i == 0) ? "R2 copy kind" : "R5 kind", gk[i], ek[i]);
      chk(gr[i] == er[i], "R3 register", gr[i], er[i]);
      chk(go[i] == eo[i], "R4 offset", longint'(signed'(go[i])), longint'(signed'(eo[i])));
      chk(gl[i] == el[i], "R6 last flag", gl[i], el[i]);
      if (ek[i] == 2'd1) chk(gd[i] == mode[0], "R10 load flag", gd[i], mode[0]);
    end
  endtask

  task automatic run_bad(input logic [15:0] list, input logic [4:0] mode, input string req);
    @(negedge clk);
    chk(in_ready, req, in_ready, 1);
    in_valid = 1; in_reglist = list; in_mode = mode; in_base = 4'd5;
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(err == 1'b1, req, err, 1);
    chk(!out_valid, req, out_valid, 0);
    @(negedge clk);
    chk(err == 1'b0, req, err, 0);
    chk(!out_valid, req, out_valid, 0);
    out_ready = 0;
  endtask

  task automatic test_reset;
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!err, "R1 err", err, 0);
    chk(in_ready, "R1 in_ready", in_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    run_seq(16'h00F1, 5'h09, 4'd3, 0);
    run_seq(16'h8001, 5'h0B, 4'd13, 1);
    run_seq(16'h0006, 5'h18, 4'd2, 0);
    run_seq(16'hFFFF, 5'h19, 4'd0, 1);
    run_seq(16'h0401, 5'h01, 4'd7, 0);
    run_seq(16'h00F0, 5'h03, 4'd1, 1);
    run_seq(16'h0008, 5'h11, 4'd4, 0);
    run_seq(16'h1234, 5'h12, 4'd9, 1);
    run_seq(16'h0001, 5'h08, 4'd15, 0);
    run_bad(16'h00FF, 5'h1B, "R7 unsupported 0x1B");
    run_bad(16'h00FF, 5'h00, "R7 unsupported 0x00");
    run_bad(16'h0003, 5'h0D, "R7 unsupported S-bit 0x0D");
    run_bad(16'h0000, 5'h09, "R8 empty list");
    run_seq(16'h0300, 5'h19, 4'd6, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule